// File: doc/BRIEF.md
# Priority Interrupt Vector Arbiter

The arbiter keeps a pending bit for every interrupt slot. Slots are grouped into priority levels, and each level holds 32 slots. A device raises its slot with a one-cycle set pulse. The arbiter compares the pending bits against the processor's current priority and raises a pending flag whenever a level strictly above that priority has work.

When the processor strobes acknowledge, the arbiter picks a winner:
- the highest eligible level is chosen first;
- within that level, the lowest-numbered bit wins.

The arbiter clears the winner's pending bit and, one cycle later, returns the vector for that slot. Vectors normally come from a writable per-slot table. If the device asserts its per-slot override enable during the acknowledge cycle, the vector the device supplies is returned instead.

Slot numbers are flat: slot = level × 32 + bit. The vector table is a simple dual-port memory: one write port for configuration and one synchronous read port addressed by the winner. This lets it map onto block RAM.

Top module: `ivarb_top`

## Requirements
- R1: `pend_o` is high, in the same cycle, exactly when some level L with L > `cur_pri_i` has at least one pending bit. Level 0 is therefore never eligible, and nothing is eligible at the top priority.
- R2: On acknowledge, the highest eligible level that has a pending bit wins, whatever requests lower levels hold.
- R3: Within the winning level, the lowest-numbered pending bit wins.
- R4: `vec_vld_o` is high in the cycle after each acknowledge and low otherwise. `vec_o` then carries the table entry of the winning slot, where slot = level*32 + bit.
- R5: A grant clears exactly the winning bit. All other pending bits keep their values, and a bit becomes pending only through its set input.
- R6: If `dyn_en_i[slot]` is high in the acknowledge cycle for the winning slot, `vec_o` returns `dyn_vec_i[slot*VEC_W +: VEC_W]` in place of the table entry.
- R7: An acknowledge while no request is eligible returns `vec_o` = 0, still with `vec_vld_o` high, and changes no pending bit.
- R8: If the winning bit's set input is high in the same cycle as its grant, the bit stays pending.
- R9: Synchronous reset clears every pending bit and drives `pend_o`, `vec_vld_o` and `vec_o` to 0.
- R10: A table write at slot S replaces the vector returned for S by later grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pri_i | input | PRI_W | Current processor priority |
| req_set_i | input | NUM_LVL*32 | One-cycle set pulse per slot |
| ack_i | input | 1 | Acknowledge strobe |
| dyn_en_i | input | NUM_LVL*32 | Per-slot vector override enable |
| dyn_vec_i | input | NUM_LVL*32*VEC_W | Per-slot device-supplied vectors |
| tbl_we_i | input | 1 | Vector table write enable |
| tbl_waddr_i | input | SLOT_W | Vector table write slot |
| tbl_wdata_i | input | VEC_W | Vector table write data |
| pend_o | output | 1 | Eligible request exists |
| vec_vld_o | output | 1 | Vector valid, one cycle after acknowledge |
| vec_o | output | VEC_W | Granted vector, 0 when nothing was eligible |

## Verification
The assertions assume two things about the inputs:
- `cur_pri_i` is stable across an acknowledge.
- The table is not written at the slot being granted in the same cycle.

The stimulus respects both. It changes priority only between acknowledges and loads the whole table before any request is raised.

Set pulses are driven only for chosen slots, so the bit-count property on grants is checked whenever no set is present alongside the acknowledge.

// File: rtl/ivarb_pkg.sv
package ivarb_pkg;
  localparam int unsigned LVL_BITS = 32;
  localparam int unsigned BIT_W    = 5;

  // Index of the lowest set bit of a level word (0 if none).
  function automatic logic [BIT_W-1:0] lowest_set(input logic [LVL_BITS-1:0] v);
    logic [BIT_W-1:0] idx;
    idx = '0;
    for (int i = LVL_BITS - 1; i >= 0; i--) begin
      if (v[i]) idx = BIT_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/ivarb_req_bank.sv
module ivarb_req_bank #(
  parameter int unsigned NSLOT  = 128,
  parameter int unsigned SLOT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSLOT-1:0]  set_i,
  input  logic              clr_en_i,
  input  logic [SLOT_W-1:0] clr_idx_i,
  output logic [NSLOT-1:0]  pend_q
);
  logic [NSLOT-1:0] clr_mask;

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_clr
      assign clr_mask[g] = clr_en_i && (clr_idx_i == SLOT_W'(g));
    end
  endgenerate

  // Set is applied after clear so a simultaneous set survives the grant.
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_mask) | set_i;
  end
endmodule

// File: rtl/ivarb_prio.sv
module ivarb_prio
  import ivarb_pkg::*;
#(
  parameter int unsigned NUM_LVL = 4,
  parameter int unsigned PRI_W   = 2,
  localparam int unsigned NSLOT  = NUM_LVL * LVL_BITS,
  localparam int unsigned SLOT_W = PRI_W + BIT_W
) (
  input  logic [NSLOT-1:0]  pend_i,
  input  logic [PRI_W-1:0]  cur_pri_i,
  output logic              any_o,
  output logic [SLOT_W-1:0] win_idx_o
);
  logic [NUM_LVL-1:0] lvl_hit;
  logic [BIT_W-1:0]   lvl_bit [NUM_LVL];

  generate
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      assign lvl_hit[l] = (|pend_i[l*LVL_BITS +: LVL_BITS]) && (PRI_W'(l) > cur_pri_i);
      assign lvl_bit[l] = lowest_set(pend_i[l*LVL_BITS +: LVL_BITS]);
    end
  endgenerate

  logic [PRI_W-1:0] win_lvl;
  logic [BIT_W-1:0] win_bit;

  // Scan upward; a later (higher) eligible level overrides earlier ones.
  always_comb begin
    any_o   = 1'b0;
    win_lvl = '0;
    win_bit = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (lvl_hit[l]) begin
        any_o   = 1'b1;
        win_lvl = PRI_W'(l);
        win_bit = lvl_bit[l];
      end
    end
  end

  assign win_idx_o = {win_lvl, win_bit};
endmodule

// File: rtl/ivarb_vec_tbl.sv
module ivarb_vec_tbl #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned VEC_W  = 9
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [VEC_W-1:0]  wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [VEC_W-1:0]  rdata_q
);
  logic [VEC_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_q <= mem[raddr_i];
  end
endmodule

// File: rtl/ivarb_top.sv
module ivarb_top
  import ivarb_pkg::*;
#(
  parameter int unsigned NUM_LVL = 4,
  parameter int unsigned VEC_W   = 9,
  localparam int unsigned PRI_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
  localparam int unsigned NSLOT  = NUM_LVL * LVL_BITS,
  localparam int unsigned SLOT_W = PRI_W + BIT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PRI_W-1:0]       cur_pri_i,
  input  logic [NSLOT-1:0]       req_set_i,
  input  logic                   ack_i,
  input  logic [NSLOT-1:0]       dyn_en_i,
  input  logic [NSLOT*VEC_W-1:0] dyn_vec_i,
  input  logic                   tbl_we_i,
  input  logic [SLOT_W-1:0]      tbl_waddr_i,
  input  logic [VEC_W-1:0]       tbl_wdata_i,
  output logic                   pend_o,
  output logic                   vec_vld_o,
  output logic [VEC_W-1:0]       vec_o
);
  logic [NSLOT-1:0]  pend_q;
  logic              any;
  logic [SLOT_W-1:0] win_idx;
  logic [VEC_W-1:0]  tbl_q;

  ivarb_req_bank #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .set_i     (req_set_i),
    .clr_en_i  (ack_i && any),
    .clr_idx_i (win_idx),
    .pend_q    (pend_q)
  );

  ivarb_prio #(.NUM_LVL(NUM_LVL), .PRI_W(PRI_W)) u_prio (
    .pend_i    (pend_q),
    .cur_pri_i (cur_pri_i),
    .any_o     (any),
    .win_idx_o (win_idx)
  );

  ivarb_vec_tbl #(.DEPTH(NSLOT), .ADDR_W(SLOT_W), .VEC_W(VEC_W)) u_tbl (
    .clk     (clk),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_waddr_i),
    .wdata_i (tbl_wdata_i),
    .re_i    (ack_i),
    .raddr_i (win_idx),
    .rdata_q (tbl_q)
  );

  logic             vld_q, hit_q, dsel_q;
  logic [VEC_W-1:0] dvec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      hit_q  <= 1'b0;
      dsel_q <= 1'b0;
      dvec_q <= '0;
    end else begin
      vld_q <= ack_i;
      if (ack_i) begin
        hit_q  <= any;
        dsel_q <= dyn_en_i[win_idx];
        dvec_q <= dyn_vec_i[win_idx*VEC_W +: VEC_W];
      end
    end
  end

  assign pend_o    = any;
  assign vec_vld_o = vld_q;
  assign vec_o     = !hit_q ? '0 : (dsel_q ? dvec_q : tbl_q);
endmodule

// File: rtl/ivarb_chk.sv
module ivarb_chk #(
  parameter int unsigned NSLOT = 128,
  parameter int unsigned PRI_W = 2,
  parameter int unsigned VEC_W = 9,
  parameter int unsigned NUM_LVL = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [PRI_W-1:0] cur_pri_i,
  input logic [NSLOT-1:0] req_set_i,
  input logic             ack_i,
  input logic             pend_o,
  input logic             vec_vld_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [NSLOT-1:0] pend_q
);
  // R1
  top_pri_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    pend_o |-> (cur_pri_i != PRI_W'(NUM_LVL - 1)));

  // R4
  vld_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> vec_vld_o);

  // R4
  no_vld_without_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_i |=> !vec_vld_o);

  // R7
  empty_ack_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !pend_o) |=> (vec_o == '0));

  // R5
  grant_clears_one_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && pend_o && (req_set_i == '0)) |=>
      ($countones(pend_q) + 1 == $countones($past(pend_q))));

  // R5
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    (req_set_i == '0) |=> ((pend_q & ~$past(pend_q)) == '0));

  // R9
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!vec_vld_o && (pend_q == '0) && !pend_o));
endmodule

bind ivarb_top ivarb_chk #(
  .NSLOT(NSLOT), .PRI_W(PRI_W), .VEC_W(VEC_W), .NUM_LVL(NUM_LVL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cur_pri_i (cur_pri_i),
  .req_set_i (req_set_i),
  .ack_i     (ack_i),
  .pend_o    (pend_o),
  .vec_vld_o (vec_vld_o),
  .vec_o     (vec_o),
  .pend_q    (pend_q)
);

// File: tb/ivarb_top_tb.sv
module ivarb_top_tb;
  localparam int NUM_LVL = 4;
  localparam int VEC_W   = 9;
  localparam int PRI_W   = 2;
  localparam int NSLOT   = NUM_LVL * 32;
  localparam int SLOT_W  = PRI_W + 5;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic [PRI_W-1:0]       cur_pri_i = '0;
  logic [NSLOT-1:0]       req_set_i = '0;
  logic                   ack_i = 1'b0;
  logic [NSLOT-1:0]       dyn_en_i = '0;
  logic [NSLOT*VEC_W-1:0] dyn_vec_i = '0;
  logic                   tbl_we_i = 1'b0;
  logic [SLOT_W-1:0]      tbl_waddr_i = '0;
  logic [VEC_W-1:0]       tbl_wdata_i = '0;
  logic                   pend_o, vec_vld_o;
  logic [VEC_W-1:0]       vec_o;

  always #10 clk = ~clk;

  ivarb_top #(.NUM_LVL(NUM_LVL), .VEC_W(VEC_W)) u_dut (
    .clk(clk), .rst(rst), .cur_pri_i(cur_pri_i), .req_set_i(req_set_i),
    .ack_i(ack_i), .dyn_en_i(dyn_en_i), .dyn_vec_i(dyn_vec_i),
    .tbl_we_i(tbl_we_i), .tbl_waddr_i(tbl_waddr_i), .tbl_wdata_i(tbl_wdata_i),
    .pend_o(pend_o), .vec_vld_o(vec_vld_o), .vec_o(vec_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [NSLOT-1:0] mpend = '0;
  logic [VEC_W-1:0] mtbl [NSLOT];
  logic [VEC_W-1:0] expq [$];
  string            tagq [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [VEC_W-1:0] tv(input int i);
    return VEC_W'(i * 3 + 5);
  endfunction

  // Model search: highest eligible level, lowest bit; -1 if none.
  function automatic int model_win();
    for (int l = NUM_LVL - 1; l > int'(cur_pri_i); l--)
      for (int b = 0; b < 32; b++)
        if (mpend[l*32 + b]) return l*32 + b;
    return -1;
  endfunction

  // Monitor: pops one expected vector per valid output.
  always @(negedge clk) begin
    if (!rst && vec_vld_o) begin
      if (expq.size() == 0) chk(0, "R4 unexpected valid", vec_o, 0);
      else begin
        logic [VEC_W-1:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(vec_o == e, t, vec_o, e);
      end
    end
  end

  task automatic raise(input int idx);
    @(negedge clk);
    req_set_i[idx] = 1'b1;
    @(negedge clk);
    req_set_i = '0;
    mpend[idx] = 1'b1;
  endtask

  // Driver: pushes the expected vector and pulses acknowledge.
  task automatic do_ack(input string tag, input int set_idx = -1);
    int w;
    @(negedge clk);
    w = model_win();
    if (w < 0) expq.push_back('0);
    else if (dyn_en_i[w]) expq.push_back(dyn_vec_i[w*VEC_W +: VEC_W]);
    else expq.push_back(mtbl[w]);
    tagq.push_back(tag);
    if (w >= 0 && w != set_idx) mpend[w] = 1'b0;
    if (set_idx >= 0) begin
      req_set_i[set_idx] = 1'b1;
      mpend[set_idx] = 1'b1;
    end
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    req_set_i = '0;
  endtask

  task automatic chk_pend(input string tag);
    logic e;
    e = (model_win() >= 0);
    chk(pend_o == e, tag, pend_o, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(pend_o == 1'b0, "R9 pend after reset", pend_o, 0);
    chk(vec_vld_o == 1'b0, "R9 vld after reset", vec_vld_o, 0);
    chk(vec_o == '0, "R9 vec after reset", vec_o, 0);
    rst = 1'b0;

    // Load the table (R10: entry values defined here)
    for (int i = 0; i < NSLOT; i++) begin
      @(negedge clk);
      tbl_we_i = 1'b1; tbl_waddr_i = SLOT_W'(i); tbl_wdata_i = tv(i);
      mtbl[i] = tv(i);
    end
    @(negedge clk);
    tbl_we_i = 1'b0;

    // R1 eligibility versus priority
    raise(40);
    cur_pri_i = 2'd0; @(negedge clk); chk_pend("R1 lvl1 above pri0");
    cur_pri_i = 2'd1; @(negedge clk); chk_pend("R1 lvl1 at pri1");
    do_ack("R7 ack with nothing eligible");
    cur_pri_i = 2'd0; @(negedge clk); chk_pend("R7 bit kept after empty ack");
    do_ack("R4 single grant slot 40");
    @(negedge clk); chk_pend("R5 pend cleared after grant");

    // R2 / R3 ordering
    raise(33); raise(35); raise(70); raise(100);
    do_ack("R2 level3 first");
    do_ack("R2 level2 next");
    do_ack("R3 lowest bit 33");
    do_ack("R3 then bit 35");
    @(negedge clk); chk_pend("R5 all cleared");

    // Level 0 never eligible
    raise(5);
    @(negedge clk); chk_pend("R1 level0 never eligible");
    do_ack("R7 level0 ack returns zero");
    mpend[5] = 1'b0;  // unreachable slot, leave it aside in the model (held at lvl0)

    // R6 device override
    raise(96);
    dyn_en_i[96] = 1'b1;
    dyn_vec_i[96*VEC_W +: VEC_W] = 9'h1AB;
    do_ack("R6 device vector override");
    dyn_en_i = '0;

    // R8 set with grant on same bit
    raise(64);
    do_ack("R8 grant with coincident set", 64);
    @(negedge clk); chk_pend("R8 bit still pending");
    do_ack("R8 second grant same slot");
    @(negedge clk); chk_pend("R8 cleared after plain grant");

    // R5 exactness and R10 table rewrite
    @(negedge clk);
    tbl_we_i = 1'b1; tbl_waddr_i = SLOT_W'(66); tbl_wdata_i = 9'h0F0; mtbl[66] = 9'h0F0;
    @(negedge clk);
    tbl_we_i = 1'b0;
    raise(65); raise(66);
    do_ack("R5 grant 65 only");
    @(negedge clk); chk_pend("R5 66 still pending");
    do_ack("R10 rewritten entry for 66");

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R4 all vectors returned", expq.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule